// File: doc/BRIEF.md
# Multi-Bank Byte FIFO

A synchronous first-in first-out byte queue whose storage is spread over several equally sized RAM banks. The write side fills one bank row after row and then moves to the next bank. The read side addresses one bank per accepted pop, and a bank-select mux picks that bank's registered output on the following cycle. The total capacity is the bank size times the bank count. This total need not be a power of two, so both pointers wrap at the exact capacity.

The bank number that steers the output mux is held in a register that loads only when a RAM read happens. This register therefore moves in step with the bank output registers. Read data stays put while pops are stalled. The first byte popped after the queue has drained and been refilled is the byte that was pushed.

The block is clocked by one clock. It takes an asynchronous active-low reset, and the reset is released synchronously inside the block.

Top module: `mbf_top`

## Requirements
- R1: While reset is active and after it is released, `empty_o` is 1, `full_o` is 0 and `rdata_o` is 0.
- R2: Bytes leave in the order they were pushed. This holds across bank boundaries and across the pointer wrap at the capacity BANK_DEPTH*NUM_BANKS, which need not be a power of two.
- R3: A push while `full_o` is 1 is ignored. Occupancy and stored contents are unchanged, and the bytes popped afterwards are only those accepted earlier.
- R4: A pop while `empty_o` is 1 is ignored. `empty_o` stays 1 and `rdata_o` keeps its value.
- R5: The byte for an accepted pop appears on `rdata_o` in the cycle after the pop. It stays unchanged until the cycle after the next accepted pop, however long pops stall.
- R6: The register that selects the output bank loads only in cycles with a RAM read. The first byte popped after the FIFO has emptied and received new data equals the byte pushed.
- R7: A push and a pop in the same cycle, with the FIFO neither full nor empty, leave the occupancy unchanged. When the FIFO is empty only the push takes effect, and when it is full only the pop does.
- R8: `full_o` is 1 exactly when BANK_DEPTH*NUM_BANKS bytes are stored. `empty_o` is 1 exactly when none are stored.
- R9: The behaviour of R2 to R8 is exact for any bank count, including both a small odd count and a count of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write a byte this cycle |
| wdata_i | input | DATA_W | Byte to write |
| full_o | output | 1 | No room for another byte |
| pop_i | input | 1 | Read a byte this cycle |
| empty_o | output | 1 | No byte stored |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after a pop |

## Verification
The bench builds two copies side by side with the same stimulus. One has 5 banks of 8 bytes, a capacity of 40 that is not a power of two. The other has 16 banks of 4 bytes, so a short run crosses every bank boundary and both pointer wraps many times. The tiny banks make stalls across a bank change, overflow and underflow at capacity, and repeated drain-and-refill restarts all reachable within a few thousand cycles.

// File: rtl/mbf_pkg.sv
package mbf_pkg;

  // Width of an index into n items, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mbf_ptr.sv
module mbf_ptr
  import mbf_pkg::*;
#(
  parameter int unsigned BANK_DEPTH = 512,
  parameter int unsigned NUM_BANKS  = 6,
  localparam int unsigned ROW_W     = idx_w(BANK_DEPTH),
  localparam int unsigned BANK_W    = idx_w(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o
);

  logic [ROW_W-1:0]  row_q, row_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              row_last, bank_last;

  assign row_last  = (row_q == ROW_W'(BANK_DEPTH - 1));
  assign bank_last = (bank_q == BANK_W'(NUM_BANKS - 1));

  // Row counts inside a bank; the bank advances on a row wrap and wraps
  // itself at the bank count, so the pointer wraps at the exact capacity.
  always_comb begin
    row_d  = row_q;
    bank_d = bank_q;
    if (adv_i) begin
      if (row_last) begin
        row_d  = '0;
        bank_d = bank_last ? '0 : bank_q + BANK_W'(1);
      end else begin
        row_d  = row_q + ROW_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      bank_q <= '0;
    end else if (adv_i) begin
      row_q  <= row_d;
      bank_q <= bank_d;
    end
  end

  assign row_o  = row_q;
  assign bank_o = bank_q;

endmodule

// File: rtl/mbf_bank.sv
module mbf_bank
  import mbf_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_DEPTH = 512,
  localparam int unsigned ROW_W     = idx_w(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ROW_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [BANK_DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // Output register of the RAM, clock-enabled by the read strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re_i) begin
      rdata_q <= mem[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/mbf_rdmux.sv
module mbf_rdmux
  import mbf_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 6,
  localparam int unsigned BANK_W   = idx_w(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        re_i,
  input  logic [BANK_W-1:0]           bank_i,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_data_i,
  output logic [BANK_W-1:0]           sel_o,
  output logic [DATA_W-1:0]           rdata_o
);

  logic [BANK_W-1:0] sel_q;
  logic [DATA_W-1:0] mux_out;

  // The select register shares the RAM read enable so it always names
  // the bank whose output register was last loaded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (re_i) begin
      sel_q <= bank_i;
    end
  end

  always_comb begin
    mux_out = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_q == BANK_W'(b)) begin
        mux_out = bank_data_i[b*DATA_W +: DATA_W];
      end
    end
  end

  assign sel_o   = sel_q;
  assign rdata_o = mux_out;

endmodule

// File: rtl/mbf_top.sv
module mbf_top
  import mbf_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_DEPTH = 512,
  parameter int unsigned NUM_BANKS  = 6,
  localparam int unsigned DEPTH     = BANK_DEPTH * NUM_BANKS,
  localparam int unsigned ROW_W     = idx_w(BANK_DEPTH),
  localparam int unsigned BANK_W    = idx_w(NUM_BANKS),
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [DATA_W-1:0] rdata_o
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  // Occupancy and flags
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             wr_en, rd_en;

  assign full_o  = (occ_q == CNT_W'(DEPTH));
  assign empty_o = (occ_q == '0);
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;

  always_comb begin
    occ_d = occ_q;
    unique case ({wr_en, rd_en})
      2'b10:   occ_d = occ_q + CNT_W'(1);
      2'b01:   occ_d = occ_q - CNT_W'(1);
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      occ_q <= '0;
    end else if (wr_en != rd_en) begin
      occ_q <= occ_d;
    end
  end

  // Pointers
  logic [ROW_W-1:0]  wr_row, rd_row;
  logic [BANK_W-1:0] wr_bank, rd_bank;

  mbf_ptr #(
    .BANK_DEPTH (BANK_DEPTH),
    .NUM_BANKS  (NUM_BANKS)
  ) wptr_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .adv_i  (wr_en),
    .row_o  (wr_row),
    .bank_o (wr_bank)
  );

  mbf_ptr #(
    .BANK_DEPTH (BANK_DEPTH),
    .NUM_BANKS  (NUM_BANKS)
  ) rptr_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .adv_i  (rd_en),
    .row_o  (rd_row),
    .bank_o (rd_bank)
  );

  // Banks
  logic [NUM_BANKS*DATA_W-1:0] bank_data;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we, bank_re;

    assign bank_we = wr_en && (wr_bank == BANK_W'(b));
    assign bank_re = rd_en && (rd_bank == BANK_W'(b));

    mbf_bank #(
      .DATA_W     (DATA_W),
      .BANK_DEPTH (BANK_DEPTH)
    ) bank_i (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .we_i    (bank_we),
      .waddr_i (wr_row),
      .wdata_i (wdata_i),
      .re_i    (bank_re),
      .raddr_i (rd_row),
      .rdata_o (bank_data[b*DATA_W +: DATA_W])
    );
  end

  // Output bank mux
  logic [BANK_W-1:0] rd_sel;

  mbf_rdmux #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) rdmux_i (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .re_i        (rd_en),
    .bank_i      (rd_bank),
    .bank_data_i (bank_data),
    .sel_o       (rd_sel),
    .rdata_o     (rdata_o)
  );

endmodule

module mbf_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned CNT_W  = 1,
  parameter int unsigned DEPTH  = 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              push_i,
  input logic              pop_i,
  input logic              full_o,
  input logic              empty_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [BANK_W-1:0] rd_sel,
  input logic [CNT_W-1:0]  occ_q
);

  // R3: a push into a full FIFO with no pop leaves it full and unchanged
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_q_n)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(occ_q)));

  // R4: a pop from an empty FIFO with no push leaves it empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_q_n)
    (empty_o && pop_i && !push_i) |=> empty_o);

  // R5: read data holds when no pop is accepted
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!pop_i || empty_o) |=> $stable(rdata_o));

  // R6: bank select moves only with a RAM read
  a_r6_sel_on_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!pop_i || empty_o) |=> $stable(rd_sel));

  // R7: accepted push and pop together keep occupancy
  a_r7_balanced: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_i && pop_i && !full_o && !empty_o) |=> $stable(occ_q));

  // R8: occupancy bounded, flags exclusive
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    (occ_q <= CNT_W'(DEPTH)) && !(full_o && empty_o));

endmodule

bind mbf_top mbf_chk #(
  .DATA_W (DATA_W),
  .BANK_W (BANK_W),
  .CNT_W  (CNT_W),
  .DEPTH  (DEPTH)
) chk_i (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .full_o  (full_o),
  .empty_o (empty_o),
  .rdata_o (rdata_o),
  .rd_sel  (rd_sel),
  .occ_q   (occ_q)
);

// File: tb/mbf_top_tb_top.sv
module mbf_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int BD_A       = 8;
  localparam int NB_A       = 5;
  localparam int BD_B       = 4;
  localparam int NB_B       = 16;
  localparam int DEPTH_A    = BD_A * NB_A;
  localparam int DEPTH_B    = BD_B * NB_B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [DW-1:0] wd = '0;
  logic          full_a, empty_a, full_b, empty_b;
  logic [DW-1:0] rd_a, rd_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbf_top #(.DATA_W(DW), .BANK_DEPTH(BD_A), .NUM_BANKS(NB_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(wd), .full_o(full_a),
    .pop_i(pop), .empty_o(empty_a), .rdata_o(rd_a));

  mbf_top #(.DATA_W(DW), .BANK_DEPTH(BD_B), .NUM_BANKS(NB_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(wd), .full_o(full_b),
    .pop_i(pop), .empty_o(empty_b), .rdata_o(rd_b));

  // Reference model state
  logic [DW-1:0] qa[$];
  logic [DW-1:0] qb[$];
  logic [DW-1:0] la = '0, lb = '0;
  bit            ja = 1'b0, jb = 1'b0;
  string         cur_tag = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare outputs with the model (called mid-cycle, after the edge settled)
  task automatic verify();
    check(empty_a == (qa.size() == 0), "R8 empty A", int'(empty_a), int'(qa.size() == 0));
    check(full_a == (qa.size() == DEPTH_A), "R8 full A", int'(full_a), int'(qa.size() == DEPTH_A));
    check(empty_b == (qb.size() == 0), "R9 empty B", int'(empty_b), int'(qb.size() == 0));
    check(full_b == (qb.size() == DEPTH_B), "R9 full B", int'(full_b), int'(qb.size() == DEPTH_B));
    check(rd_a == la, ja ? cur_tag : "R5 hold A", int'(rd_a), int'(la));
    check(rd_b == lb, jb ? {"R9 ", cur_tag} : "R5 R9 hold B", int'(rd_b), int'(lb));
  endtask

  task automatic model(input bit p, input bit o, input logic [DW-1:0] d);
    int sa, sb;
    sa = qa.size();
    sb = qb.size();
    ja = 1'b0;
    jb = 1'b0;
    if (o && sa > 0) begin la = qa.pop_front(); ja = 1'b1; end
    if (p && sa < DEPTH_A) qa.push_back(d);
    if (o && sb > 0) begin lb = qb.pop_front(); jb = 1'b1; end
    if (p && sb < DEPTH_B) qb.push_back(d);
  endtask

  task automatic step(input bit p, input bit o, input string tag);
    @(negedge clk);
    verify();
    cur_tag = tag;
    push = p;
    pop = o;
    wd = DW'($urandom);
    model(p, o, wd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int pops;
    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    check(empty_a && !full_a && rd_a == '0, "R1 reset A", int'({empty_a, full_a}), 2);
    check(empty_b && !full_b && rd_b == '0, "R1 reset B", int'({empty_b, full_b}), 2);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, "R1");

    // R3: fill past capacity of both copies, then R2/R3 drain order
    for (int i = 0; i < DEPTH_B + 5; i++) step(1'b1, 1'b0, "R3");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R7 full");
    for (int i = 0; i < DEPTH_B + 5; i++) step(1'b0, 1'b1, "R2");
    // R4: pops on empty
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, "R7 empty");
    step(1'b0, 1'b1, "R7 empty");
    step(1'b0, 1'b0, "R7 empty");

    // R6: repeated drain and refill with stalls, crossing banks
    for (int i = 0; i < 90; i++) begin
      int burst;
      burst = 1 + int'($urandom_range(2));
      for (int k = 0; k < burst; k++) step(1'b1, 1'b0, "R6");
      repeat ($urandom_range(3)) step(1'b0, 1'b0, "R6");
      for (int k = 0; k < burst + 1; k++) begin
        step(1'b0, 1'b1, "R6");
        repeat ($urandom_range(2)) step(1'b0, 1'b0, "R5");
      end
    end

    // R7: balanced traffic keeps occupancy
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R7");
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, "R7");
    pops = 0;
    step(1'b0, 1'b0, "R7");
    while (!empty_a && pops < 100) begin
      step(1'b0, 1'b1, "R7");
      pops++;
      @(posedge clk);
      #1;
    end
    check(pops == 10, "R7 occupancy after balanced traffic", pops, 10);

    // R2/R5/R9: random traffic with stalls in both directions
    for (int i = 0; i < 4000; i++) begin
      bit p, o;
      if ((i / 500) % 2 == 0) begin
        p = ($urandom_range(99) < 65);
        o = ($urandom_range(99) < 40);
      end else begin
        p = ($urandom_range(99) < 40);
        o = ($urandom_range(99) < 65);
      end
      step(p, o, "R2 R9");
    end
    for (int i = 0; i < DEPTH_B + 2; i++) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule